// File: doc/BRIEF.md
# Luma 16x16 Intra Predictor (Vertical / Horizontal / DC)

This block builds the 16x16 array of 8-bit luma prediction samples for one macroblock. The caller presents 16 samples from the row above, 16 samples from the column to the left, availability flags for those neighbours and a mode code, all at once, and pulses `start`. The block then emits one 16-sample row per clock, in order from the top row to the bottom row. Each row is marked by `out_valid`, and the last row comes with a `done` pulse.

Three prediction modes are built in. Vertical copies the row above into every output row. Horizontal fills each output row with its own left neighbour. DC fills the whole block with the rounded mean of the neighbours. In DC mode a missing neighbour side is patched before summing, so one adder tree covers every availability case. A missing top row is first set to mid-grey. A missing left column then copies the top side, and a still-missing top side copies the left side. A mode code that is not handled raises a one-cycle error flag and produces no rows.

Top module: `luma16_intra_pred`

## Requirements
- R1: Only bits [3:0] of `mode_code` are decoded: 0 selects vertical, 1 selects horizontal, 2 selects DC. Bits [7:4] have no effect.
- R2: In vertical mode, sample x of every output row equals `top_ref[8x+7:8x]`.
- R3: In horizontal mode, every sample of row y equals `left_ref[8y+7:8y]`.
- R4: In DC mode with both sides available, every sample equals (sum of 16 top + sum of 16 left + 16) >> 5.
- R5: The left side counts as available only when both `left_hi_avail` and `left_lo_avail` are 1.
- R6: In DC mode with top missing and left available, the left samples stand in for the top samples, so the value is (2*sumLeft + 16) >> 5.
- R7: In DC mode with left missing and top available, the top samples stand in for the left samples, so the value is (2*sumTop + 16) >> 5.
- R8: In DC mode with neither side available, every sample equals 128.
- R9: A low nibble of 3 or above, accepted by `start` while idle, pulses `mode_err` for one cycle, leaves `busy` low and produces no rows.
- R10: A `start` accepted at clock edge T sets `busy` after T. Row y appears with `out_valid` high and `out_row_idx` = y after edge T+1+y. `done` is high together with row 15. `busy` falls after edge T+16.
- R11: `start` is ignored while `busy` is high. The rows in flight are unaffected.
- R12: Synchronous reset clears `busy`, `out_valid`, `done` and `mode_err`, and abandons a block that is being emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load strobe; sampled only while idle |
| mode_code | input | 8 | Prediction mode; low nibble decoded |
| top_ref | input | 128 | Row above, sample x in bits [8x+7:8x] |
| left_ref | input | 128 | Column to the left, sample y in bits [8y+7:8y] |
| top_avail | input | 1 | Row above usable |
| left_hi_avail | input | 1 | Upper half of left column usable |
| left_lo_avail | input | 1 | Lower half of left column usable |
| busy | output | 1 | Block accepted and rows still pending |
| out_valid | output | 1 | `out_row` holds a prediction row |
| out_row_idx | output | 4 | Row number of `out_row` |
| out_row | output | 128 | Prediction row, sample x in bits [8x+7:8x] |
| done | output | 1 | High with the last row |
| mode_err | output | 1 | One-cycle pulse for an unsupported mode |

## Verification
The assertions assume that reset is held for at least one clock before any check applies, and that the reference and flag inputs are stable at each rising edge. The bench therefore changes every input only on the falling edge and opens with several reset cycles. The properties also assume that `start` is the only way rows are produced. The bench drives `start` both while idle and while a block is in flight, including at the edge where the last row leaves. It also covers every availability combination, including a single left-half flag, and mode codes whose upper nibble is non-zero.

// File: rtl/luma16_pkg.sv
package luma16_pkg;
  typedef enum logic [1:0] {
    PM_VERT = 2'd0,
    PM_HORZ = 2'd1,
    PM_DC   = 2'd2,
    PM_BAD  = 2'd3
  } pmode_t;

  function automatic pmode_t decode_mode(input logic [3:0] nib);
    case (nib)
      4'd0:    decode_mode = PM_VERT;
      4'd1:    decode_mode = PM_HORZ;
      4'd2:    decode_mode = PM_DC;
      default: decode_mode = PM_BAD;
    endcase
  endfunction
endpackage

// File: rtl/luma16_dc_unit.sv
module luma16_dc_unit #(
  parameter int SW = 8,
  parameter int N  = 16
) (
  input  logic [N*SW-1:0] top_i,
  input  logic [N*SW-1:0] left_i,
  input  logic            top_ok_i,
  input  logic            left_ok_i,
  output logic [SW-1:0]   dc_o
);
  localparam int SHIFT = $clog2(2*N);
  localparam int SUMW  = SW + SHIFT + 1;
  localparam logic [SW-1:0] MID = SW'(1 << (SW-1));

  logic [N*SW-1:0] top_p1, left_p, top_p2;
  logic [SUMW-1:0] acc;

  // patch order: grey top, left from top, top from left
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_patch
      assign top_p1[g*SW +: SW] = top_ok_i  ? top_i[g*SW +: SW]  : MID;
      assign left_p[g*SW +: SW] = left_ok_i ? left_i[g*SW +: SW] : top_p1[g*SW +: SW];
      assign top_p2[g*SW +: SW] = top_ok_i  ? top_p1[g*SW +: SW] : left_p[g*SW +: SW];
    end
  endgenerate

  always_comb begin
    acc = SUMW'(N);
    for (int i = 0; i < N; i++) begin
      acc = acc + SUMW'(top_p2[i*SW +: SW]) + SUMW'(left_p[i*SW +: SW]);
    end
  end

  assign dc_o = acc[SHIFT +: SW];

  always_comb begin
    AST_NEITHER_GREY: assert (top_ok_i || left_ok_i || dc_o == MID); // R8
  end
endmodule

// File: rtl/luma16_row_gen.sv
module luma16_row_gen
  import luma16_pkg::*;
#(
  parameter int SW = 8,
  parameter int N  = 16,
  localparam int RW = $clog2(N)
) (
  input  pmode_t          mode_i,
  input  logic [N*SW-1:0] top_i,
  input  logic [N*SW-1:0] left_i,
  input  logic [SW-1:0]   dc_i,
  input  logic [RW-1:0]   row_i,
  output logic [N*SW-1:0] row_o
);
  logic [SW-1:0] left_sel;
  assign left_sel = left_i[row_i*SW +: SW];

  genvar c;
  generate
    for (c = 0; c < N; c++) begin : g_col
      always_comb begin
        case (mode_i)
          PM_VERT: row_o[c*SW +: SW] = top_i[c*SW +: SW];
          PM_HORZ: row_o[c*SW +: SW] = left_sel;
          default: row_o[c*SW +: SW] = dc_i;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/luma16_intra_pred.sv
module luma16_intra_pred
  import luma16_pkg::*;
#(
  parameter int SW = 8,
  parameter int N  = 16,
  localparam int RW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [7:0]      mode_code,
  input  logic [N*SW-1:0] top_ref,
  input  logic [N*SW-1:0] left_ref,
  input  logic            top_avail,
  input  logic            left_hi_avail,
  input  logic            left_lo_avail,
  output logic            busy,
  output logic            out_valid,
  output logic [RW-1:0]   out_row_idx,
  output logic [N*SW-1:0] out_row,
  output logic            done,
  output logic            mode_err
);
  pmode_t          mode_d, mode_q;
  logic [N*SW-1:0] top_q, left_q;
  logic [SW-1:0]   dc_d, dc_q;
  logic [RW-1:0]   cnt_q;
  logic [N*SW-1:0] row_w;
  logic            left_ok;

  assign mode_d  = decode_mode(mode_code[3:0]);
  assign left_ok = left_hi_avail & left_lo_avail;

  luma16_dc_unit #(.SW(SW), .N(N)) dc_i (
    .top_i(top_ref), .left_i(left_ref),
    .top_ok_i(top_avail), .left_ok_i(left_ok), .dc_o(dc_d)
  );

  luma16_row_gen #(.SW(SW), .N(N)) rg_i (
    .mode_i(mode_q), .top_i(top_q), .left_i(left_q),
    .dc_i(dc_q), .row_i(cnt_q), .row_o(row_w)
  );

  // operand registers, no reset needed
  always_ff @(posedge clk) begin
    if (!busy && start && mode_d != PM_BAD) begin
      top_q  <= top_ref;
      left_q <= left_ref;
      dc_q   <= dc_d;
      mode_q <= mode_d;
    end
    if (busy) begin
      out_row     <= row_w;
      out_row_idx <= cnt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      out_valid <= 1'b0;
      done      <= 1'b0;
      mode_err  <= 1'b0;
      cnt_q     <= '0;
    end else begin
      out_valid <= busy;
      done      <= 1'b0;
      mode_err  <= 1'b0;
      if (busy) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == RW'(N-1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        if (mode_d == PM_BAD) begin
          mode_err <= 1'b1;
        end else begin
          busy  <= 1'b1;
          cnt_q <= '0;
        end
      end
    end
  end

  AST_DONE_LAST_ROW: assert property (@(posedge clk) disable iff (rst)
    done |-> (out_valid && out_row_idx == RW'(N-1))); // R10
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |-> out_row_idx == $past(out_row_idx) + 1'b1); // R10
  AST_ERR_NO_ROW: assert property (@(posedge clk) disable iff (rst)
    mode_err |-> (!busy && !out_valid)); // R9
  AST_VERT_COPY: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mode_q == PM_VERT) |-> out_row == top_q); // R2
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !done) |-> $stable(mode_q)); // R11
endmodule

// File: tb/luma16_intra_pred_tb.sv
module luma16_intra_pred_tb_top;
  localparam int N = 16;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] mode_code = '0;
  logic [N*SW-1:0] top_ref = '0, left_ref = '0;
  logic top_avail = 1'b0, left_hi_avail = 1'b0, left_lo_avail = 1'b0;
  logic busy, out_valid, done, mode_err;
  logic [3:0] out_row_idx;
  logic [N*SW-1:0] out_row;

  always #10 clk = ~clk;

  luma16_intra_pred dut_i (
    .clk(clk), .rst(rst), .start(start), .mode_code(mode_code),
    .top_ref(top_ref), .left_ref(left_ref), .top_avail(top_avail),
    .left_hi_avail(left_hi_avail), .left_lo_avail(left_lo_avail),
    .busy(busy), .out_valid(out_valid), .out_row_idx(out_row_idx),
    .out_row(out_row), .done(done), .mode_err(mode_err)
  );

  int checks = 0, failures = 0;
  string cur_req = "R12";
  bit started = 0;

  // behavioural reference model
  int m_top[N], m_left[N];
  int m_mode, m_dc, m_cnt;
  bit m_busy, m_valid, m_done, m_err;
  int m_idx;
  int m_row[N];

  always @(posedge clk) begin
    bit was_busy;
    started = 1;
    was_busy = m_busy;
    if (rst) begin
      m_busy = 0; m_valid = 0; m_done = 0; m_err = 0;
    end else begin
      m_done = 0; m_err = 0;
      m_valid = was_busy;
      if (was_busy) begin
        m_idx = m_cnt;
        for (int x = 0; x < N; x++)
          m_row[x] = (m_mode == 0) ? m_top[x] : (m_mode == 1) ? m_left[m_cnt] : m_dc;
        if (m_cnt == N-1) begin m_done = 1; m_busy = 0; end
        m_cnt++;
      end else if (start) begin
        int nib, st, sl;
        bit lok;
        nib = mode_code & 15;
        if (nib > 2) m_err = 1;
        else begin
          m_mode = nib; m_busy = 1; m_cnt = 0; st = 0; sl = 0;
          for (int i = 0; i < N; i++) begin
            m_top[i] = top_ref[i*SW +: SW]; m_left[i] = left_ref[i*SW +: SW];
            st += m_top[i]; sl += m_left[i];
          end
          lok = left_hi_avail && left_lo_avail;
          if (top_avail && lok) m_dc = (st + sl + 16) / 32;
          else if (top_avail)   m_dc = (2*st + 16) / 32;
          else if (lok)         m_dc = (2*sl + 16) / 32;
          else                  m_dc = 128;
        end
      end
    end
  end

  task automatic chk(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("busy", busy, m_busy);
      chk("out_valid", out_valid, m_valid);
      chk("done", done, m_done);
      chk("mode_err", mode_err, m_err);
      if (m_valid) begin
        chk("row_idx", out_row_idx, m_idx);
        for (int x = 0; x < N; x++) chk("sample", out_row[x*SW +: SW], m_row[x]);
      end
    end
  end

  task automatic fill(input int kind);
    for (int i = 0; i < N; i++) begin
      top_ref[i*SW +: SW]  = (kind == 1) ? 8'hFF : 8'($urandom);
      left_ref[i*SW +: SW] = (kind == 1) ? 8'hFF : 8'($urandom);
    end
  endtask

  task automatic run(input string req, input logic [7:0] md, input bit ta,
                     input bit lh, input bit ll, input int kind);
    @(negedge clk);
    cur_req = req;
    fill(kind);
    mode_code = md; top_avail = ta; left_hi_avail = lh; left_lo_avail = ll;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (19) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cur_req = "R12";
    repeat (4) @(negedge clk);
    rst = 1'b0;
    run("R2",  8'h00, 1, 1, 1, 0);
    run("R3",  8'h01, 1, 1, 1, 0);
    run("R4",  8'h02, 1, 1, 1, 0);
    run("R4",  8'h02, 1, 1, 1, 1);   // all-255 extreme
    run("R6",  8'h02, 0, 1, 1, 0);
    run("R7",  8'h02, 1, 0, 0, 0);
    run("R5",  8'h02, 1, 1, 0, 0);
    run("R5",  8'h02, 1, 0, 1, 0);
    run("R8",  8'h02, 0, 0, 0, 0);
    run("R8",  8'h02, 0, 1, 0, 0);
    run("R1",  8'hF0, 1, 1, 1, 0);
    run("R1",  8'h52, 0, 1, 1, 0);
    run("R9",  8'h03, 1, 1, 1, 0);
    run("R9",  8'h07, 1, 1, 1, 0);
    run("R9",  8'h0F, 1, 1, 1, 0);
    // R11: start during a block
    @(negedge clk);
    cur_req = "R11"; fill(0); mode_code = 8'h00; top_avail = 1; start = 1;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    fill(0); mode_code = 8'h01; start = 1;
    @(negedge clk); start = 0;
    repeat (11) @(negedge clk);
    start = 1; mode_code = 8'h03;       // held across the final row edge
    repeat (3) @(negedge clk);
    start = 0;
    repeat (20) @(negedge clk);
    // R10: back-to-back blocks
    cur_req = "R10";
    fill(0); mode_code = 8'h02; start = 1;
    repeat (40) @(negedge clk);
    start = 0;
    repeat (20) @(negedge clk);
    // R12: reset mid-block
    cur_req = "R12";
    fill(0); mode_code = 8'h01; start = 1;
    @(negedge clk); start = 0;
    repeat (5) @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    repeat (20) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule